// File: doc/BRIEF.md
# Compare-Driven Two-Output PWM Generator

This block produces two pulse-width-modulated outputs from one free-running 16-bit signed counter. The counter is stepped by a power-of-two prescaler. It starts at a programmable start value, climbs to a programmable end value and then returns to the start value. Each output has its own pair of compare values: the first turns the output on and the second turns it off. Because both compares are arbitrary signed values, the same hardware gives edge-aligned or center-aligned waveforms, with unsigned or signed counting.

All seven timing values (start, mid-point, end and the four output compares) are double-buffered. Software writes the staging copies, then requests a load. The load is applied at once, at the mid-period point, at the end of the period, or at either of these. It can also be limited to every Nth such opportunity. The two outputs can run independently. They can also form a complementary pair built from one source compare channel, with separate dead-time delays on each rising edge. Each output has its own polarity and enable.

Top module: `pwm_submodule`

## Requirements
- R1: After reset both pins are low. All registers are zero, which leaves both outputs disabled with non-inverted polarity.
- R2: On each prescaler tick the counter moves one step up. When it equals the end value (address 2), it goes back to the start value (address 0) instead. Address 1 holds the mid-point value.
- R3: A prescaler tick comes once every 2^P input clocks, where P is configuration bits [2:0] (configuration is at address 7). The counter does not change between ticks.
- R4: One clock after the counter equals an output's set compare, that output goes active. One clock after it equals the clear compare, the output goes inactive. When both compares match at once, clear wins. Output A uses addresses 3 (set) and 4 (clear). Output B uses addresses 5 (set) and 6 (clear).
- R5: Writes to addresses 0 to 6 change only staging copies and have no effect on the pins until a load. Writing 1 to bit 0 of address 10 makes a load pending. While a load is pending, writes to addresses 0 to 6 are dropped.
- R6: With load mode 0 (configuration bits [4:3] = 00), a pending load is applied on the clock after the request. The pending flag clears when the load is applied.
- R7: Load mode 1 applies a pending load at a mid-point tick (counter equals the mid-point value). Mode 2 applies it at an end tick. Mode 3 applies it at either. If a load coincides with the wrap, the counter takes the newly loaded start value.
- R8: In load modes 1 to 3, only every (F+1)th opportunity is a load point, where F is configuration bits [7:5]. F is ignored in mode 0.
- R9: When configuration bit 8 is 0, the outputs are complementary. The source is channel A's compare output, or channel B's when bit 9 is 1. Output A follows the source and output B follows its inverse. Each rising edge is delayed by that output's dead time, in clocks (address 8 for A, address 9 for B). Falling edges are not delayed. When bit 8 is 1, each output follows its own compare with no dead time.
- R10: Configuration bit 10 (A) and bit 11 (B) invert the active level of their output.
- R11: When the enable bit is 0 (bit 12 for A, bit 13 for B), that pin is held at its inactive level, which equals its polarity bit.
- R12: Negative start and compare values work as signed values. A count from -10 to +10 with compares at -4/+4 gives a pulse centered on zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW (4) | Register address |
| wr_data | input | CW (16) | Register write data |
| pwm_a | output | 1 | Output A pin |
| pwm_b | output | 1 | Output B pin |

## Verification
The pins lag the counter by two registers. A compare hit is seen at a pin two clock edges after the counter takes the matching value, plus the dead time when the outputs run as a complementary pair. A configuration write changes polarity or enable at the pins one edge later. An immediate load request takes effect on the following edge. The bench steps a behavioural model at the same rising edge as the design, using the same write inputs, and compares both pins on every falling edge, so each result is checked exactly in the cycle it is due. Targeted counts over whole periods then confirm tie handling, the absence of overlap, polarity and enable.

// File: rtl/pwm_sm_pkg.sv
package pwm_sm_pkg;

  // Prescale select width and reload-frequency field width
  localparam int unsigned PSW  = 3;
  localparam int unsigned FW   = 3;
  localparam int unsigned NCMP = 7;
  localparam int unsigned CFGW = 14;

  // Buffered value indices (equal to their write addresses)
  localparam int unsigned I_INIT = 0;
  localparam int unsigned I_MID  = 1;
  localparam int unsigned I_END  = 2;
  localparam int unsigned I_ASET = 3;
  localparam int unsigned I_ACLR = 4;
  localparam int unsigned I_BSET = 5;
  localparam int unsigned I_BCLR = 6;

  // Unbuffered addresses
  localparam int unsigned ADDR_CFG  = 7;
  localparam int unsigned ADDR_DTA  = 8;
  localparam int unsigned ADDR_DTB  = 9;
  localparam int unsigned ADDR_LDOK = 10;

  typedef enum logic [1:0] {
    RL_IMM  = 2'd0,
    RL_MID  = 2'd1,
    RL_END  = 2'd2,
    RL_BOTH = 2'd3
  } reload_e;

  typedef struct packed {
    logic           en_b;
    logic           en_a;
    logic           pol_b;
    logic           pol_a;
    logic           src_b;
    logic           indep;
    logic [FW-1:0]  every;
    reload_e        mode;
    logic [PSW-1:0] psc;
  } cfg_t;

  // Next compare-output state: clear has priority over set
  function automatic logic cmp_step(input logic cur, input logic hit_set, input logic hit_clr);
    if (hit_clr) return 1'b0;
    if (hit_set) return 1'b1;
    return cur;
  endfunction

  // Pin level from enable, polarity and internal active state
  function automatic logic pin_level(input logic en, input logic pol, input logic act);
    return en ? (act ^ pol) : pol;
  endfunction

endpackage

// File: rtl/pwm_sm_timebase.sv
module pwm_sm_timebase
  import pwm_sm_pkg::*;
#(
  parameter int unsigned CW = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [PSW-1:0] psc,
  input  logic [CW-1:0]  init_now,
  input  logic [CW-1:0]  mid,
  input  logic [CW-1:0]  fin,
  output logic [CW-1:0]  cnt,
  output logic           tick,
  output logic           half_ev,
  output logic           full_ev
);

  localparam int unsigned PDW = (1 << PSW) - 1;

  logic [PDW-1:0] psc_cnt;
  logic [PDW-1:0] psc_mask;

  function automatic logic [PDW-1:0] div_mask(input logic [PSW-1:0] p);
    logic [PDW:0] sh;
    sh    = '0;
    sh[p] = 1'b1;
    return sh[PDW-1:0] - PDW'(1);
  endfunction

  assign psc_mask = div_mask(psc);
  assign tick     = (psc_cnt >= psc_mask);
  assign half_ev  = tick && (cnt == mid);
  assign full_ev  = tick && (cnt == fin);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psc_cnt <= '0;
      cnt     <= '0;
    end else begin
      psc_cnt <= tick ? '0 : psc_cnt + 1'b1;
      if (tick) begin
        cnt <= (cnt == fin) ? init_now : cnt + 1'b1;
      end
    end
  end

  assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && (cnt != fin)) |=> (cnt == $past(cnt) + 1'b1));

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt));

  assert_div_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (psc_cnt == '0));

endmodule

// File: rtl/pwm_sm_reload.sv
module pwm_sm_reload
  import pwm_sm_pkg::*;
#(
  parameter int unsigned CW = 16,
  parameter int unsigned AW = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [AW-1:0]             wr_addr,
  input  logic [CW-1:0]             wr_data,
  input  reload_e                   mode,
  input  logic [FW-1:0]             every,
  input  logic                      half_ev,
  input  logic                      full_ev,
  output logic [NCMP-1:0][CW-1:0]   act_q,
  output logic [CW-1:0]             buf_init,
  output logic                      load_now
);

  logic [NCMP-1:0][CW-1:0] buf_q;
  logic [FW-1:0]           opp_cnt;
  logic [1:0]              mode_b;
  logic                    ldok_q;
  logic                    ldok_set;
  logic                    opp;
  logic                    reload_pt;

  assign mode_b    = mode;
  assign opp       = (mode_b[0] & half_ev) | (mode_b[1] & full_ev);
  assign reload_pt = opp && (opp_cnt >= every);
  assign load_now  = ldok_q && ((mode == RL_IMM) || reload_pt);
  assign ldok_set  = wr_en && (wr_addr == AW'(ADDR_LDOK)) && wr_data[0];
  assign buf_init  = buf_q[I_INIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ldok_q  <= 1'b0;
      opp_cnt <= '0;
    end else begin
      if (ldok_set)      ldok_q <= 1'b1;
      else if (load_now) ldok_q <= 1'b0;
      if (opp) opp_cnt <= reload_pt ? '0 : opp_cnt + 1'b1;
    end
  end

  for (genvar g = 0; g < NCMP; g++) begin : g_val
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        buf_q[g] <= '0;
        act_q[g] <= '0;
      end else begin
        if (wr_en && (wr_addr == AW'(g)) && !ldok_q) buf_q[g] <= wr_data;
        if (load_now) act_q[g] <= buf_q[g];
      end
    end
  end

  assert_ldok_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (load_now && !ldok_set) |=> !ldok_q);

  assert_active_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !load_now |=> $stable(act_q));

  assert_stage_locked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ldok_q |=> $stable(buf_q));

  assert_opp_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ldok_q && (mode != RL_IMM) && !opp) |=> ldok_q);

endmodule

// File: rtl/pwm_sm_compare.sv
module pwm_sm_compare
  import pwm_sm_pkg::*;
#(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cnt,
  input  logic [CW-1:0] set_v,
  input  logic [CW-1:0] clr_v,
  output logic          raw
);

  logic hit_set;
  logic hit_clr;

  assign hit_set = (cnt == set_v);
  assign hit_clr = (cnt == clr_v);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) raw <= 1'b0;
    else        raw <= cmp_step(raw, hit_set, hit_clr);
  end

  assert_clear_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    hit_clr |=> !raw);

  assert_set_drives_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_set && !hit_clr) |=> raw);

endmodule

// File: rtl/pwm_sm_deadtime.sv
module pwm_sm_deadtime #(
  parameter int unsigned DTW = 11
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           pre,
  input  logic [DTW-1:0] dt,
  output logic           out
);

  logic [DTW-1:0] wait_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wait_cnt <= '0;
      out      <= 1'b0;
    end else if (!pre) begin
      wait_cnt <= '0;
      out      <= 1'b0;
    end else if (wait_cnt >= dt) begin
      out <= 1'b1;
    end else begin
      wait_cnt <= wait_cnt + 1'b1;
    end
  end

  assert_fall_prompt_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !pre |=> !out);

  assert_rise_needs_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out) |-> $past(pre));

endmodule

// File: rtl/pwm_submodule.sv
module pwm_submodule
  import pwm_sm_pkg::*;
#(
  parameter int unsigned CW  = 16,
  parameter int unsigned DTW = 11,
  parameter int unsigned AW  = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [CW-1:0] wr_data,
  output logic          pwm_a,
  output logic          pwm_b
);

  cfg_t                    cfg_q;
  logic [1:0][DTW-1:0]     dt_q;
  logic [NCMP-1:0][CW-1:0] act_q;
  logic [CW-1:0]           buf_init;
  logic [CW-1:0]           init_now;
  logic [CW-1:0]           cnt;
  logic                    load_now;
  logic                    tick;
  logic                    half_ev;
  logic                    full_ev;
  logic [1:0]              raw;
  logic [1:0]              pre;
  logic [1:0][DTW-1:0]     dt_eff;
  logic [1:0]              dto;
  logic                    src;

  // Unbuffered configuration and dead-time registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      dt_q  <= '0;
    end else if (wr_en) begin
      if (wr_addr == AW'(ADDR_CFG)) cfg_q   <= cfg_t'(wr_data[CFGW-1:0]);
      if (wr_addr == AW'(ADDR_DTA)) dt_q[0] <= wr_data[DTW-1:0];
      if (wr_addr == AW'(ADDR_DTB)) dt_q[1] <= wr_data[DTW-1:0];
    end
  end

  pwm_sm_reload #(.CW(CW), .AW(AW)) u_reload (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .mode     (cfg_q.mode),
    .every    (cfg_q.every),
    .half_ev  (half_ev),
    .full_ev  (full_ev),
    .act_q    (act_q),
    .buf_init (buf_init),
    .load_now (load_now)
  );

  // A load that coincides with the wrap takes the incoming start value
  assign init_now = load_now ? buf_init : act_q[I_INIT];

  pwm_sm_timebase #(.CW(CW)) u_timebase (
    .clk      (clk),
    .rst_n    (rst_n),
    .psc      (cfg_q.psc),
    .init_now (init_now),
    .mid      (act_q[I_MID]),
    .fin      (act_q[I_END]),
    .cnt      (cnt),
    .tick     (tick),
    .half_ev  (half_ev),
    .full_ev  (full_ev)
  );

  for (genvar ch = 0; ch < 2; ch++) begin : g_cmp
    pwm_sm_compare #(.CW(CW)) u_cmp (
      .clk   (clk),
      .rst_n (rst_n),
      .cnt   (cnt),
      .set_v (act_q[I_ASET + 2*ch]),
      .clr_v (act_q[I_ACLR + 2*ch]),
      .raw   (raw[ch])
    );
  end

  // Independent or complementary routing
  always_comb begin
    src = cfg_q.src_b ? raw[1] : raw[0];
    if (cfg_q.indep) begin
      pre    = raw;
      dt_eff = '0;
    end else begin
      pre    = {~src, src};
      dt_eff = dt_q;
    end
  end

  for (genvar ch = 0; ch < 2; ch++) begin : g_dt
    pwm_sm_deadtime #(.DTW(DTW)) u_dt (
      .clk   (clk),
      .rst_n (rst_n),
      .pre   (pre[ch]),
      .dt    (dt_eff[ch]),
      .out   (dto[ch])
    );
  end

  assign pwm_a = pin_level(cfg_q.en_a, cfg_q.pol_a, dto[0]);
  assign pwm_b = pin_level(cfg_q.en_b, cfg_q.pol_b, dto[1]);

  assert_no_overlap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!cfg_q.indep) |-> !(dto[0] && dto[1]));

  assert_tick_gates_events_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (half_ev || full_ev) |-> tick);

endmodule

// File: tb/pwm_submodule_test.sv
module pwm_submodule_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        pwm_a;
  logic        pwm_b;

  always #5 clk = ~clk;

  pwm_submodule uut (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .pwm_a   (pwm_a),
    .pwm_b   (pwm_b)
  );

  // Behavioural reference state
  int          m_psc;
  logic [15:0] m_cnt;
  logic [15:0] m_stage [7];
  logic [15:0] m_live  [7];
  logic [13:0] m_cfg;
  int          m_dt    [2];
  bit          m_ldok;
  int          m_opp;
  bit          m_raw   [2];
  int          m_wait  [2];
  bit          m_out   [2];

  int    checks = 0;
  int    fails  = 0;
  bit    done   = 0;
  string phase  = "R1 reset";

  function automatic void model_reset();
    m_psc = 0; m_cnt = '0; m_cfg = '0; m_ldok = 0; m_opp = 0;
    for (int i = 0; i < 7; i++) begin m_stage[i] = '0; m_live[i] = '0; end
    for (int c = 0; c < 2; c++) begin
      m_dt[c] = 0; m_raw[c] = 0; m_wait[c] = 0; m_out[c] = 0;
    end
  endfunction

  function automatic void model_step();
    int mask;
    bit tick, half, full, opp, rpt, load, src, old_ldok;
    int md, every;
    bit pre [2];
    int dte [2];
    mask  = (1 << int'(m_cfg[2:0])) - 1;
    tick  = (m_psc >= mask);
    half  = tick && (m_cnt == m_live[1]);
    full  = tick && (m_cnt == m_live[2]);
    md    = int'(m_cfg[4:3]);
    every = int'(m_cfg[7:5]);
    opp   = (((md == 1) || (md == 3)) && half) || (((md == 2) || (md == 3)) && full);
    rpt   = opp && (m_opp >= every);
    load  = m_ldok && ((md == 0) || rpt);
    // output stage from the compare state held this cycle
    src = m_cfg[9] ? m_raw[1] : m_raw[0];
    if (m_cfg[8]) begin
      pre[0] = m_raw[0]; pre[1] = m_raw[1]; dte[0] = 0; dte[1] = 0;
    end else begin
      pre[0] = src; pre[1] = !src; dte[0] = m_dt[0]; dte[1] = m_dt[1];
    end
    for (int c = 0; c < 2; c++) begin
      if (!pre[c]) begin m_out[c] = 0; m_wait[c] = 0; end
      else if (m_wait[c] >= dte[c]) m_out[c] = 1;
      else m_wait[c] = m_wait[c] + 1;
    end
    for (int c = 0; c < 2; c++) begin
      if (m_cnt == m_live[4 + 2*c]) m_raw[c] = 0;
      else if (m_cnt == m_live[3 + 2*c]) m_raw[c] = 1;
    end
    if (tick) begin
      if (m_cnt == m_live[2]) m_cnt = load ? m_stage[0] : m_live[0];
      else m_cnt = m_cnt + 16'd1;
      m_psc = 0;
    end else begin
      m_psc = m_psc + 1;
    end
    if (opp) m_opp = rpt ? 0 : m_opp + 1;
    if (load) for (int i = 0; i < 7; i++) m_live[i] = m_stage[i];
    old_ldok = m_ldok;
    if (wr_en && wr_addr == 4'd10 && wr_data[0]) m_ldok = 1;
    else if (load) m_ldok = 0;
    if (wr_en) begin
      if (wr_addr < 4'd7 && !old_ldok) m_stage[wr_addr] = wr_data;
      if (wr_addr == 4'd7) m_cfg = wr_data[13:0];
      if (wr_addr == 4'd8) m_dt[0] = int'(wr_data[10:0]);
      if (wr_addr == 4'd9) m_dt[1] = int'(wr_data[10:0]);
    end
  endfunction

  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else model_step();
  end

  // Per-cycle comparison of both pins against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic ea, eb;
      ea = m_cfg[12] ? (m_out[0] ^ m_cfg[10]) : m_cfg[10];
      eb = m_cfg[13] ? (m_out[1] ^ m_cfg[11]) : m_cfg[11];
      checks++;
      if (pwm_a !== ea || pwm_b !== eb) begin
        fails++;
        $display("FAIL %s: pins a,b actual %b%b expected %b%b at %0t",
                 phase, pwm_a, pwm_b, ea, eb, $time);
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int addr, input logic [15:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 4'(addr); wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    chk("R1 pin A low in reset", int'(pwm_a), 0);
    chk("R1 pin B low in reset", int'(pwm_b), 0);
    rst_n = 1'b1;
    idle(5);
    chk("R1 pin A low after reset", int'(pwm_a), 0);

    // R2 R4 R6: edge-aligned, independent, immediate load
    phase = "R2/R4/R6 edge-aligned immediate";
    wr(0, 16'd0); wr(1, 16'd10); wr(2, 16'd19);
    wr(3, 16'd0); wr(4, 16'd5); wr(5, 16'd3); wr(6, 16'd12);
    wr(7, 16'h3100);
    wr(10, 16'd1);
    idle(80);

    // R3: prescale by 4 and by 128
    phase = "R3 prescale div4";
    wr(7, 16'h3102);
    idle(200);
    phase = "R3 prescale div128";
    wr(7, 16'h3107);
    idle(3000);
    phase = "R3 prescale div1";
    wr(7, 16'h3100);
    idle(40);

    // R4: equal set and clear keeps B inactive
    phase = "R4 tie clear wins";
    wr(5, 16'd7); wr(6, 16'd7); wr(10, 16'd1);
    idle(30);
    n = 0;
    for (int i = 0; i < 40; i++) begin @(negedge clk); if (pwm_b) n++; end
    chk("R4 tie keeps B low", n, 0);

    // R5: staged writes invisible without a load
    phase = "R5 staged write without load";
    wr(4, 16'd15);
    idle(60);
    // R5 R7: full-cycle load, write during pending load dropped
    phase = "R5/R7 end-point load with dropped write";
    wr(7, 16'h3110);
    wr(10, 16'd1);
    wr(3, 16'd2);
    idle(80);

    // R7: mid-point load
    phase = "R7 mid-point load";
    wr(7, 16'h3108);
    wr(4, 16'd8); wr(10, 16'd1);
    idle(60);
    // R8: both points, every third opportunity
    phase = "R8 every third opportunity";
    wr(7, 16'h3158);
    wr(4, 16'd11); wr(10, 16'd1);
    idle(100);
    phase = "R8 end point every fourth";
    wr(7, 16'h3170);
    wr(4, 16'd6); wr(10, 16'd1);
    idle(150);

    // R12: signed center-aligned, loaded at the wrap
    phase = "R12 signed center-aligned";
    wr(7, 16'h3110);
    wr(0, 16'hFFF6); wr(1, 16'h0000); wr(2, 16'h000A);
    wr(3, 16'hFFFC); wr(4, 16'h0004); wr(5, 16'hFFFA); wr(6, 16'h0006);
    wr(10, 16'd1);
    idle(100);
    n = 0;
    for (int i = 0; i < 21; i++) begin @(negedge clk); if (pwm_a) n++; end
    chk("R12 A active 8 of 21 clocks", n, 8);

    // R9: complementary pair with dead time
    phase = "R9 complementary source A";
    wr(8, 16'd3); wr(9, 16'd2);
    wr(7, 16'h3010);
    idle(100);
    n = 0;
    for (int i = 0; i < 63; i++) begin @(negedge clk); if (pwm_a && pwm_b) n++; end
    chk("R9 no overlap source A", n, 0);
    phase = "R9 complementary source B";
    wr(7, 16'h3210);
    idle(60);
    n = 0;
    for (int i = 0; i < 21; i++) begin @(negedge clk); if (pwm_a) n++; end
    chk("R9 A high 12-2-... source B with dead time", n, 12 - 3);
    n = 0;
    for (int i = 0; i < 21; i++) begin @(negedge clk); if (pwm_b) n++; end
    chk("R9 B high with dead time", n, 9 - 2);

    // R10: polarity inversion, independent
    phase = "R10 polarity";
    wr(3, 16'd0); wr(4, 16'd5); wr(10, 16'd1);
    wr(7, 16'h3D10);
    idle(60);
    n = 0;
    for (int i = 0; i < 21; i++) begin @(negedge clk); if (!pwm_a) n++; end
    chk("R10 inverted A low 5 of 21", n, 5);

    // R11: disabled outputs sit at their polarity level
    phase = "R11 disabled inverted";
    wr(7, 16'h0D10);
    n = 0;
    for (int i = 0; i < 30; i++) begin @(negedge clk); if (pwm_a && pwm_b) n++; end
    chk("R11 disabled pins held at 1", n, 30);
    phase = "R11 disabled plain";
    wr(7, 16'h0110);
    n = 0;
    for (int i = 0; i < 30; i++) begin @(negedge clk); if (pwm_a || pwm_b) n++; end
    chk("R11 disabled pins held at 0", n, 0);

    done = 1;
    summary();
    $finish;
  end

endmodule